// File: doc/BRIEF.md
# Looping Address Generator for a Copy Channel

This block generates the byte addresses that a copy channel reads from and writes to. It has two independent sides: one for the read (source) stream and one for the write (destination) stream. A load strobe captures a new pair of base addresses. After that, every step strobe moves both sides forward by one byte.

Each side runs in one of two modes. In linear mode the address counts upward and wraps modulo the full address width. In looping mode the address cycles through a power-of-two window that begins at the side's own base address. The base does not need to be aligned to the window. The window size is the base-2 logarithm held in a two-bit field, so the possible windows are 1, 2, 4 and 8 bytes. A window of 1 (field value 0) holds the address at its base.

The mode word is read on every step, so a change to it takes effect from the next step onward. Both outputs are registered and follow a strobe one clock later. The reset input is asynchronous and active low. Its release is synchronised inside the block, so strobes are accepted from the third rising edge after the reset input goes high.

Top module: `loop_addr_gen`

## Requirements
- R1: While reset is active, and after it is released until the first load, both address outputs read zero.
- R2: A load strobe makes each output equal its base input on the next clock, and the step count of both sides starts again from zero.
- R3: With a side's loop-enable bit clear, each step adds exactly one to that side's address, wrapping modulo 2^ADDR_W.
- R4: The source loop-enable bit is mode bit 12 and its log2 window field is mode bits 15:14. When looping with field value k, the source address after n steps is base + (n mod 2^k).
- R5: The destination loop-enable bit is mode bit 13 and its log2 window field is mode bits 17:16. When looping with field value k, the destination address after n steps is base + (n mod 2^k).
- R6: The two sides advance on the same step strobe but each one wraps according to its own enable bit and window field. Mode bits outside 17:12 have no effect on either side.
- R7: With loop enabled and a window field of 0, a step leaves the address at its base.
- R8: With neither strobe asserted, both outputs keep their value.
- R9: When load and step are asserted in the same cycle, the load wins and the outputs equal the new bases.
- R10: The looping window starts at the base itself, so an unaligned base wraps back to that base and not to an aligned boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture new bases and restart both step counts |
| step_i | input | 1 | Advance both sides by one byte |
| src_base_i | input | ADDR_W | Source base address |
| dst_base_i | input | ADDR_W | Destination base address |
| mode_i | input | MODE_W | Mode word holding the loop-enable bits and window fields |
| src_addr_o | output | ADDR_W | Current source address |
| dst_addr_o | output | ADDR_W | Current destination address |

## Verification
The main sweep runs every combination of loop enable and window field on the source side while the destination uses a different setting. Each run is 20 steps long, so each window wraps at least twice, and any mix-up of field positions or of the two sides shows up as a wrong period. One linear run starts just below the top of the address space and confirms the modular carry. Another run starts at an unaligned base inside a 4-byte window, which separates wrapping at the base from wrapping at an aligned boundary. Further patterns set every unrelated mode bit, hold both strobes low, and assert load together with step, to show that each of these leaves the outputs exactly as the requirements predict.

// File: rtl/loop_addr_pkg.sv
package loop_addr_pkg;

  // Width of a log2 window-size field.
  localparam int unsigned LOOP_SZ_W = 2;

  // Number of address sides: index 0 is source, index 1 is destination.
  localparam int unsigned NUM_SIDES = 2;

  typedef struct packed {
    logic                 loop_en;
    logic [LOOP_SZ_W-1:0] log2_win;
  } side_cfg_t;

endpackage

// File: rtl/loop_rst_sync.sv
module loop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/loop_mode_decode.sv
module loop_mode_decode
  import loop_addr_pkg::*;
#(
  parameter int unsigned MODE_W     = 32,
  parameter int unsigned SRC_EN_BIT = 12,
  parameter int unsigned DST_EN_BIT = 13,
  parameter int unsigned SRC_SZ_LSB = 14,
  parameter int unsigned DST_SZ_LSB = 16
) (
  input  logic [MODE_W-1:0]            mode_i,
  output side_cfg_t [NUM_SIDES-1:0]    cfg_o
);

  always_comb begin
    cfg_o[0].loop_en  = mode_i[SRC_EN_BIT];
    cfg_o[0].log2_win = mode_i[SRC_SZ_LSB +: LOOP_SZ_W];
    cfg_o[1].loop_en  = mode_i[DST_EN_BIT];
    cfg_o[1].log2_win = mode_i[DST_SZ_LSB +: LOOP_SZ_W];
  end

endmodule

// File: rtl/loop_addr_side.sv
module loop_addr_side
  import loop_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  input  side_cfg_t         cfg_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] off_q,  off_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              en;

  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] off_inc;
  logic [ADDR_W-1:0] off_wrap;

  // Window mask: all ones in linear mode, 2^k-1 in looping mode.
  always_comb begin
    if (cfg_i.loop_en) begin
      win_mask = (ONE << cfg_i.log2_win) - ONE;
    end else begin
      win_mask = '1;
    end
    off_inc  = off_q + ONE;
    off_wrap = off_inc & win_mask;
  end

  // Next-state selection; load has priority over step.
  always_comb begin
    base_d = base_q;
    off_d  = off_q;
    addr_d = addr_q;
    en     = 1'b0;
    if (load_i) begin
      en     = 1'b1;
      base_d = base_i;
      off_d  = '0;
      addr_d = base_i;
    end else if (step_i) begin
      en     = 1'b1;
      off_d  = off_wrap;
      addr_d = base_q + off_wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
      addr_q <= '0;
    end else if (en) begin
      base_q <= base_d;
      off_q  <= off_d;
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/loop_addr_gen.sv
module loop_addr_gen
  import loop_addr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned MODE_W     = 32,
  parameter int unsigned SRC_EN_BIT = 12,
  parameter int unsigned DST_EN_BIT = 13,
  parameter int unsigned SRC_SZ_LSB = 14,
  parameter int unsigned DST_SZ_LSB = 16,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o
);

  logic                            rst_q_n;
  side_cfg_t [NUM_SIDES-1:0]       side_cfg;
  logic [NUM_SIDES-1:0][ADDR_W-1:0] side_base;
  logic [NUM_SIDES-1:0][ADDR_W-1:0] side_addr;

  loop_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  loop_mode_decode #(
    .MODE_W     (MODE_W),
    .SRC_EN_BIT (SRC_EN_BIT),
    .DST_EN_BIT (DST_EN_BIT),
    .SRC_SZ_LSB (SRC_SZ_LSB),
    .DST_SZ_LSB (DST_SZ_LSB)
  ) u_decode (
    .mode_i (mode_i),
    .cfg_o  (side_cfg)
  );

  assign side_base[0] = src_base_i;
  assign side_base[1] = dst_base_i;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    loop_addr_side #(
      .ADDR_W (ADDR_W)
    ) u_side (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .load_i (load_i),
      .step_i (step_i),
      .base_i (side_base[s]),
      .cfg_i  (side_cfg[s]),
      .addr_o (side_addr[s])
    );
  end

  assign src_addr_o = side_addr[0];
  assign dst_addr_o = side_addr[1];

endmodule

// File: rtl/loop_addr_gen_chk.sv
module loop_addr_gen_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned MODE_W     = 32,
  parameter int unsigned SRC_EN_BIT = 12,
  parameter int unsigned DST_EN_BIT = 13,
  parameter int unsigned SRC_SZ_LSB = 14,
  parameter int unsigned DST_SZ_LSB = 16
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              load_i,
  input logic              step_i,
  input logic [ADDR_W-1:0] src_base_i,
  input logic [ADDR_W-1:0] dst_base_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic [ADDR_W-1:0] dst_addr_o
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] sb_q, db_q;
  logic [ADDR_W-1:0] s_mask, d_mask;
  logic              s_loop, d_loop;

  always_comb begin
    s_loop = mode_i[SRC_EN_BIT];
    d_loop = mode_i[DST_EN_BIT];
    s_mask = (ONE << mode_i[SRC_SZ_LSB +: 2]) - ONE;
    d_mask = (ONE << mode_i[DST_SZ_LSB +: 2]) - ONE;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sb_q <= '0;
      db_q <= '0;
    end else if (load_i) begin
      sb_q <= src_base_i;
      db_q <= dst_base_i;
    end
  end

  // R2 and R9: a load (with or without step) shows the bases next cycle.
  assert_load_bases_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    load_i |=> (src_addr_o == $past(src_base_i)) && (dst_addr_o == $past(dst_base_i)));

  // R3: linear source side counts by one.
  assert_src_linear_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_i && !load_i && !s_loop) |=> src_addr_o == $past(src_addr_o) + ONE);

  // R3: linear destination side counts by one.
  assert_dst_linear_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_i && !load_i && !d_loop) |=> dst_addr_o == $past(dst_addr_o) + ONE);

  // R4: looping source stays inside its window above the base.
  assert_src_window_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_i && !load_i && s_loop) |=> ((src_addr_o - sb_q) & ~$past(s_mask)) == '0);

  // R5: looping destination stays inside its window above the base.
  assert_dst_window_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_i && !load_i && d_loop) |=> ((dst_addr_o - db_q) & ~$past(d_mask)) == '0);

  // R7: a window of one keeps the source at its base.
  assert_src_hold_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (step_i && !load_i && s_loop && mode_i[SRC_SZ_LSB +: 2] == 2'd0) |=> src_addr_o == sb_q);

  // R8: no strobe, no movement.
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!step_i && !load_i) |=> $stable(src_addr_o) && $stable(dst_addr_o));

endmodule

bind loop_addr_gen loop_addr_gen_chk #(
  .ADDR_W     (ADDR_W),
  .MODE_W     (MODE_W),
  .SRC_EN_BIT (SRC_EN_BIT),
  .DST_EN_BIT (DST_EN_BIT),
  .SRC_SZ_LSB (SRC_SZ_LSB),
  .DST_SZ_LSB (DST_SZ_LSB)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .load_i     (load_i),
  .step_i     (step_i),
  .src_base_i (src_base_i),
  .dst_base_i (dst_base_i),
  .mode_i     (mode_i),
  .src_addr_o (src_addr_o),
  .dst_addr_o (dst_addr_o)
);

// File: tb/loop_addr_gen_bench.sv
module loop_addr_gen_bench;

  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic        step_i;
  logic [31:0] src_base_i;
  logic [31:0] dst_base_i;
  logic [31:0] mode_i;
  logic [31:0] src_addr_o;
  logic [31:0] dst_addr_o;

  int checks = 0;
  int errors = 0;

  loop_addr_gen u_loop_addr_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .step_i     (step_i),
    .src_base_i (src_base_i),
    .dst_base_i (dst_base_i),
    .mode_i     (mode_i),
    .src_addr_o (src_addr_o),
    .dst_addr_o (dst_addr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_mode(input bit sen, input int sk,
                                          input bit den, input int dk, input bit junk);
    logic [31:0] m;
    m = junk ? 32'hFFFC_0FFF : 32'h0;
    m[12]    = sen;
    m[15:14] = 2'(sk);
    m[13]    = den;
    m[17:16] = 2'(dk);
    return m;
  endfunction

  function automatic logic [31:0] expect_addr(input logic [31:0] base, input bit en,
                                              input int k, input int n);
    if (en) return base + 32'(n % (1 << k));
    return base + 32'(n);
  endfunction

  // Load, then step n_steps times checking both sides every cycle.
  task automatic run(input string req, input logic [31:0] sb, input logic [31:0] db,
                     input bit sen, input int sk, input bit den, input int dk,
                     input bit junk, input int n_steps);
    mode_i     = mk_mode(sen, sk, den, dk, junk);
    src_base_i = sb;
    dst_base_i = db;
    load_i     = 1'b1;
    step_i     = 1'b0;
    tick();
    chk({req, " R2 load src"}, src_addr_o, sb);
    chk({req, " R2 load dst"}, dst_addr_o, db);
    load_i = 1'b0;
    step_i = 1'b1;
    src_base_i = ~sb;
    dst_base_i = ~db;
    for (int n = 1; n <= n_steps; n++) begin
      tick();
      chk({req, " src"}, src_addr_o, expect_addr(sb, sen, sk, n));
      chk({req, " dst"}, dst_addr_o, expect_addr(db, den, dk, n));
    end
    step_i = 1'b0;
  endtask

  initial begin
    rst_n      = 1'b0;
    load_i     = 1'b0;
    step_i     = 1'b0;
    src_base_i = 32'h1234_5678;
    dst_base_i = 32'h8765_4321;
    mode_i     = 32'h0;
    repeat (3) tick();
    chk("R1 reset src", src_addr_o, 32'h0);
    chk("R1 reset dst", dst_addr_o, 32'h0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 after release src", src_addr_o, 32'h0);
    chk("R1 after release dst", dst_addr_o, 32'h0);

    // R4 R5 R6: sweep of source settings against a different destination setting.
    for (int se = 0; se < 2; se++) begin
      for (int sk = 0; sk < 4; sk++) begin
        run("R4 R6 sweep", 32'h0000_1000 + 32'(sk * 16), 32'h0004_2000,
            bit'(se), sk, bit'(1 - se), 3 - sk, 1'b0, 20);
      end
    end
    // R5: sweep destination settings with linear source.
    for (int dk = 0; dk < 4; dk++) begin
      run("R5 dst sweep", 32'h0000_0100, 32'h0000_0200 + 32'(dk),
          1'b0, 0, 1'b1, dk, 1'b0, 20);
    end
    // R6: unrelated mode bits set have no effect.
    run("R6 junk bits", 32'h0000_0400, 32'h0000_0800, 1'b1, 2, 1'b1, 1, 1'b1, 12);
    run("R6 junk linear", 32'h0000_0400, 32'h0000_0800, 1'b0, 3, 1'b0, 2, 1'b1, 12);
    // R3: linear wrap at the top of the address space.
    run("R3 modular wrap", 32'hFFFF_FFFD, 32'hFFFF_FFFE, 1'b0, 0, 1'b0, 0, 1'b0, 6);
    // R7: window of one holds both sides.
    run("R7 hold", 32'h0000_0ABC, 32'h0000_0DEF, 1'b1, 0, 1'b1, 0, 1'b0, 5);
    // R10: unaligned base wraps to itself.
    run("R10 unaligned", 32'h0000_0013, 32'h0000_0027, 1'b1, 2, 1'b1, 3, 1'b0, 10);

    // R8: no strobes, outputs keep their value (last state base+10 mod windows).
    begin
      logic [31:0] s_hold, d_hold;
      s_hold = src_addr_o;
      d_hold = dst_addr_o;
      src_base_i = 32'hDEAD_BEEF;
      dst_base_i = 32'hCAFE_F00D;
      mode_i     = 32'hFFFF_FFFF;
      repeat (4) tick();
      chk("R8 idle src", src_addr_o, s_hold);
      chk("R8 idle dst", dst_addr_o, d_hold);
    end

    // R9: load and step together, load wins; then one step continues from zero.
    mode_i     = mk_mode(1'b0, 0, 1'b0, 0, 1'b0);
    src_base_i = 32'h0000_5000;
    dst_base_i = 32'h0000_6000;
    load_i     = 1'b1;
    step_i     = 1'b1;
    tick();
    chk("R9 priority src", src_addr_o, 32'h0000_5000);
    chk("R9 priority dst", dst_addr_o, 32'h0000_6000);
    load_i = 1'b0;
    tick();
    chk("R9 step after src", src_addr_o, 32'h0000_5001);
    chk("R9 step after dst", dst_addr_o, 32'h0000_6001);
    step_i = 1'b0;

    // R2: reload mid-stream restarts the count for a looping side.
    run("R2 reload", 32'h0000_5002, 32'h0000_6003, 1'b1, 1, 1'b1, 2, 1'b0, 3);

    // R1: reset again mid-run clears outputs.
    rst_n = 1'b0;
    tick();
    chk("R1 re-reset src", src_addr_o, 32'h0);
    chk("R1 re-reset dst", dst_addr_o, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule